// File: doc/BRIEF.md
# Interconnect Access Error Detector

This block sits next to the address decoder of an on-chip interconnect and looks at every transaction the decoder dispatches. It recognises two kinds of local access fault: an access whose address decodes to no target at all, and an access that enters from a fabric port and decodes to a fabric target, forming a loop. The two kinds are treated differently. An access that hits nothing is stopped. A read gets a response marked corrupt and also pulses a core fault line. A write has its data thrown away. A loop access is only reported and is still forwarded to its target unchanged.

Both kinds record the same sticky error flag in a status register. A second sticky flag is raised when a further error of that type arrives while the first flag is still set. Software clears either flag by writing a one to it. An enable register gates the error flag onto a level interrupt, and the interrupt stays high until the flag is cleared. Software reaches both registers through a small word-addressed read/write port whose reads have no side effects.

Top module: `access_err_detector`

## Requirements
- R1: After reset, both status flags, the enable bit, `irq`, `rsp_valid`, `core_fault`, `fwd_valid` and `wr_drop` are all 0.
- R2: The status word is at byte offset 0x0, with the multiple-error flag at bit 31 and the access-error flag at bit 0. The enable word is at offset 0x4, with the error enable at bit 0. Every other bit reads 0, and any other offset reads 0.
- R3: A valid read with `txn_hit`=0 is not forwarded. In the following cycle, `rsp_valid`, `rsp_corrupt` and `core_fault` are each 1 for exactly one cycle.
- R4: A valid write with `txn_hit`=0 is not forwarded and raises `wr_drop` in the same cycle. It produces no response and no core fault.
- R5: A valid access with `txn_hit`=1, `txn_src_fabric`=1 and `txn_dst_fabric`=1 is forwarded (`fwd_valid`=1 in the same cycle) and also sets the access-error flag.
- R6: Any other access with `txn_hit`=1 is forwarded. It sets no flag and produces no response.
- R7: The access-error flag reads 1 starting in the cycle after an R3, R4 or R5 event.
- R8: An error event that arrives while the access-error flag is already 1 sets the multiple-error flag. A single error after the flags were cleared leaves it at 0.
- R9: Writing 1 to a status flag clears it. Writing 0 leaves it unchanged.
- R10: `irq` equals the access-error flag ANDed with the enable bit.
- R11: If an error event and a clearing write to the same flag happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | Decoded transaction present this cycle |
| txn_is_write | input | 1 | 1 = write, 0 = read |
| txn_src_fabric | input | 1 | Initiator is a fabric port |
| txn_hit | input | 1 | Address decoded to some target |
| txn_dst_fabric | input | 1 | Decoded target is a fabric port |
| fwd_valid | output | 1 | Transaction forwarded to its target |
| wr_drop | output | 1 | Write data of this transaction is discarded |
| rsp_valid | output | 1 | Error read response issued |
| rsp_corrupt | output | 1 | Corrupt attribute of the error response |
| core_fault | output | 1 | Fault pulse toward the core for an unmapped read |
| irq | output | 1 | Level interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |

## Verification
Two operations can land in the same cycle: a hardware error event, and a software write-one-to-clear aimed at the flag that event sets. The bench first sets the access-error flag. It then drives an unmapped read in the same cycle as a write of all ones to the status word. Because the flag was already set, this one cycle exercises both the set-over-clear rule and the multiple-error rule. The outcome is judged one cycle later at the register port: both flags must read 1, and `irq` must still follow the enable bit.

// File: rtl/aed_pkg.sv
// Package: shared types and register layout for the access error detector.
// Assumes a word-addressed register port with byte offsets.
package aed_pkg;

    // One decoded transaction as seen from the decoder.
    typedef struct packed {
        logic is_write;
        logic src_fabric;
        logic hit;
        logic dst_fabric;
    } txn_t;

    // Classification result for one transaction.
    typedef struct packed {
        logic forward;
        logic unmapped_rd;
        logic unmapped_wr;
        logic loopback;
    } txn_class_t;

    localparam int unsigned STATUS_OFS = 0;
    localparam int unsigned ENABLE_OFS = 4;
    localparam int unsigned ERR_BIT    = 0;

endpackage

// File: rtl/aed_classify.sv
// Module: aed_classify
// Sorts a decoded transaction into forward / unmapped read / unmapped write /
// loopback. Purely combinational; assumes txn fields are only meaningful
// while valid is high.
module aed_classify
    import aed_pkg::*;
(
    input  logic       valid,
    input  txn_t       txn,
    output txn_class_t cls
);

    // Decide the fate of the transaction from the decode result.
    always_comb begin
        cls.forward     = valid &&  txn.hit;
        cls.unmapped_rd = valid && !txn.hit && !txn.is_write;
        cls.unmapped_wr = valid && !txn.hit &&  txn.is_write;
        cls.loopback    = valid &&  txn.hit &&  txn.src_fabric && txn.dst_fabric;
    end

endmodule

// File: rtl/aed_rsp_gen.sv
// Module: aed_rsp_gen
// Issues a one-cycle corrupt read response and core fault pulse in the cycle
// after an unmapped read. Assumes at most one transaction per cycle.
module aed_rsp_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic unmapped_rd,
    output logic rsp_valid,
    output logic rsp_corrupt,
    output logic core_fault
);

    logic pend_q;

    // Register the unmapped-read event into a response slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= unmapped_rd;
        end
    end

    // The only response this block makes is the error response.
    always_comb begin
        rsp_valid   = pend_q;
        rsp_corrupt = pend_q;
        core_fault  = pend_q;
    end

endmodule

// File: rtl/aed_status.sv
// Module: aed_status
// Holds the sticky error flags, the enable bit, the level interrupt and the
// register read mux. The flags are write-one-to-clear, and a hardware set
// wins over a clear in the same cycle.
module aed_status
    import aed_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              err_flag,
    output logic              mult_flag,
    output logic              err_en,
    output logic              irq
);

    localparam int unsigned MULT_BIT = DATA_W - 1;

    logic wr_status;
    logic wr_enable;
    logic clr_err;
    logic clr_mult;

    // Decode which register a write targets and which flags it clears.
    always_comb begin
        wr_status = reg_wr && (reg_addr == ADDR_W'(STATUS_OFS));
        wr_enable = reg_wr && (reg_addr == ADDR_W'(ENABLE_OFS));
        clr_err   = wr_status && reg_wdata[ERR_BIT];
        clr_mult  = wr_status && reg_wdata[MULT_BIT];
    end

    // Sticky error flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (err_evt) begin
            err_flag <= 1'b1;
        end else if (clr_err) begin
            err_flag <= 1'b0;
        end
    end

    // Multiple-error flag: set when an error finds the flag already set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_flag <= 1'b0;
        end else if (err_evt && err_flag) begin
            mult_flag <= 1'b1;
        end else if (clr_mult) begin
            mult_flag <= 1'b0;
        end
    end

    // Enable register: only the error-enable bit is implemented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_en <= 1'b0;
        end else if (wr_enable) begin
            err_en <= reg_wdata[ERR_BIT];
        end
    end

    // Level interrupt from the flag gated by its enable.
    always_comb begin
        irq = err_flag && err_en;
    end

    // Side-effect-free read mux; reserved bits and unknown offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(STATUS_OFS)) begin
            reg_rdata[ERR_BIT]  = err_flag;
            reg_rdata[MULT_BIT] = mult_flag;
        end else if (reg_addr == ADDR_W'(ENABLE_OFS)) begin
            reg_rdata[ERR_BIT] = err_en;
        end
    end

endmodule

// File: rtl/access_err_detector.sv
// Module: access_err_detector
// Top: watches each decoded transaction, blocks unmapped accesses (error
// response for reads, dropped data for writes), flags loopbacks while still
// forwarding them, and keeps a W1C status with a level interrupt.
module access_err_detector
    import aed_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic              txn_is_write,
    input  logic              txn_src_fabric,
    input  logic              txn_hit,
    input  logic              txn_dst_fabric,
    output logic              fwd_valid,
    output logic              wr_drop,
    output logic              rsp_valid,
    output logic              rsp_corrupt,
    output logic              core_fault,
    output logic              irq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    txn_t       txn;
    txn_class_t cls;
    logic       err_evt;
    logic       err_flag;
    logic       mult_flag;
    logic       err_en;

    // Gather the transaction fields into one struct.
    always_comb begin
        txn.is_write   = txn_is_write;
        txn.src_fabric = txn_src_fabric;
        txn.hit        = txn_hit;
        txn.dst_fabric = txn_dst_fabric;
    end

    aed_classify u_cls (
        .valid (txn_valid),
        .txn   (txn),
        .cls   (cls)
    );

    // Routing outputs and the combined error event.
    always_comb begin
        fwd_valid = cls.forward;
        wr_drop   = cls.unmapped_wr;
        err_evt   = cls.unmapped_rd || cls.unmapped_wr || cls.loopback;
    end

    aed_rsp_gen u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .unmapped_rd (cls.unmapped_rd),
        .rsp_valid   (rsp_valid),
        .rsp_corrupt (rsp_corrupt),
        .core_fault  (core_fault)
    );

    aed_status #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_evt   (err_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .err_flag  (err_flag),
        .mult_flag (mult_flag),
        .err_en    (err_en),
        .irq       (irq)
    );

endmodule

// File: rtl/aed_checker.sv
// Module: aed_checker
// Temporal checks on the detector, bound into every instance of the top.
module aed_checker (
    input logic clk,
    input logic rst_n,
    input logic txn_valid,
    input logic txn_is_write,
    input logic txn_src_fabric,
    input logic txn_hit,
    input logic txn_dst_fabric,
    input logic fwd_valid,
    input logic wr_drop,
    input logic rsp_valid,
    input logic core_fault,
    input logic irq,
    input logic err_flag,
    input logic mult_flag
);

    logic bad_rd;
    logic bad_wr;
    logic loop;
    logic any_err;

    // Independent restatement of the error kinds from the raw inputs.
    always_comb begin
        bad_rd  = txn_valid && !txn_hit && !txn_is_write;
        bad_wr  = txn_valid && !txn_hit &&  txn_is_write;
        loop    = txn_valid && txn_hit && txn_src_fabric && txn_dst_fabric;
        any_err = bad_rd || bad_wr || loop;
    end

    AST_UNMAPPED_RD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        bad_rd |=> (rsp_valid && core_fault)); // R3
    AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !bad_rd) |=> !rsp_valid); // R3
    AST_UNMAPPED_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |-> (wr_drop && !fwd_valid)); // R4
    AST_LOOP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        loop |-> fwd_valid); // R5
    AST_HIT_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_hit) |=> !rsp_valid); // R6
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> err_flag); // R11
    AST_MULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (any_err && err_flag) |=> mult_flag); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> err_flag); // R10

endmodule

bind access_err_detector aed_checker u_aed_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .txn_valid      (txn_valid),
    .txn_is_write   (txn_is_write),
    .txn_src_fabric (txn_src_fabric),
    .txn_hit        (txn_hit),
    .txn_dst_fabric (txn_dst_fabric),
    .fwd_valid      (fwd_valid),
    .wr_drop        (wr_drop),
    .rsp_valid      (rsp_valid),
    .core_fault     (core_fault),
    .irq            (irq),
    .err_flag       (err_flag),
    .mult_flag      (mult_flag)
);

// File: tb/tb_access_err_detector.sv
module tb_access_err_detector;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NVEC   = 8;
    localparam logic [DATA_W-1:0] ALL1 = '1;

    // {wr, src, hit, dst, exp_fwd, exp_drop, exp_rsp, exp_flag}
    localparam logic [7:0] VECS [NVEC] = '{
        8'b0_0_0_0_0_0_1_1,   // unmapped read
        8'b1_0_0_0_0_1_0_1,   // unmapped write
        8'b0_0_1_0_1_0_0_0,   // plain hit read
        8'b1_1_1_0_1_0_0_0,   // fabric source, normal target
        8'b0_0_1_1_1_0_0_0,   // normal source, fabric target
        8'b0_1_1_1_1_0_0_1,   // loopback read
        8'b1_1_1_1_1_0_0_1,   // loopback write
        8'b1_1_0_1_0_1_0_1    // unmapped write from fabric
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 1'b0, txn_is_write = 1'b0, txn_src_fabric = 1'b0;
    logic txn_hit = 1'b0, txn_dst_fabric = 1'b0;
    logic fwd_valid, wr_drop, rsp_valid, rsp_corrupt, core_fault, irq;
    logic reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    access_err_detector #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .txn_valid(txn_valid), .txn_is_write(txn_is_write),
        .txn_src_fabric(txn_src_fabric), .txn_hit(txn_hit),
        .txn_dst_fabric(txn_dst_fabric),
        .fwd_valid(fwd_valid), .wr_drop(wr_drop), .rsp_valid(rsp_valid),
        .rsp_corrupt(rsp_corrupt), .core_fault(core_fault), .irq(irq),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational read, called away from the clock edge.
    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Drive one transaction on a negedge; leaves the bench one cycle later.
    task automatic txn(input logic w, input logic s, input logic h, input logic d);
        @(negedge clk);
        txn_valid = 1'b1; txn_is_write = w; txn_src_fabric = s;
        txn_hit = h; txn_dst_fabric = d;
        #1;
    endtask

    task automatic txn_end();
        @(negedge clk);
        txn_valid = 1'b0; txn_is_write = 1'b0; txn_src_fabric = 1'b0;
        txn_hit = 1'b0; txn_dst_fabric = 1'b0;
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        rd(8'h00, d); chk("R1 status", d, '0);
        rd(8'h04, d); chk("R1 enable", d, '0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rsp/fault", {30'b0, rsp_valid, core_fault}, 0);
        chk("R1 fwd/drop", {30'b0, fwd_valid, wr_drop}, 0);

        // Vector walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] v;
            v = VECS[i];
            wr(8'h00, ALL1);
            txn(v[7], v[6], v[5], v[4]);
            chk($sformatf("R3/R4/R5/R6 fwd vec%0d", i), {31'b0, fwd_valid}, {31'b0, v[3]});
            chk($sformatf("R4 drop vec%0d", i), {31'b0, wr_drop}, {31'b0, v[2]});
            txn_end();
            chk($sformatf("R3 rsp vec%0d", i),
                {29'b0, rsp_valid, rsp_corrupt, core_fault}, {29'b0, v[1], v[1], v[1]});
            rd(8'h00, d);
            chk($sformatf("R7 flag vec%0d (R8 mult clear)", i), d, {31'b0, v[0]});
            @(negedge clk); #1;
            chk($sformatf("R3 one-shot vec%0d", i), {31'b0, rsp_valid}, 0);
        end

        // R2: layout, reserved bits, unknown offsets
        wr(8'h04, ALL1);
        rd(8'h04, d); chk("R2 enable only bit0", d, 32'h0000_0001);
        rd(8'h08, d); chk("R2 unknown offset", d, '0);
        wr(8'h00, ALL1);
        txn(1'b0, 1'b0, 1'b0, 1'b0); txn_end();
        txn(1'b1, 1'b0, 1'b0, 1'b0); txn_end();
        rd(8'h00, d); chk("R2 R8 both flags", d, 32'h8000_0001);

        // R10: irq follows flag and enable
        chk("R10 irq en=1", {31'b0, irq}, 1);
        wr(8'h04, '0); #1;
        chk("R10 irq en=0", {31'b0, irq}, 0);
        wr(8'h04, 32'h1); #1;
        chk("R10 irq re-enabled", {31'b0, irq}, 1);

        // R9: write-one-to-clear per bit
        wr(8'h00, '0);
        rd(8'h00, d); chk("R9 zero write keeps", d, 32'h8000_0001);
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, d); chk("R9 clear err only", d, 32'h8000_0000);
        chk("R10 irq after clear", {31'b0, irq}, 0);
        wr(8'h00, 32'h8000_0000);
        rd(8'h00, d); chk("R9 clear mult", d, '0);

        // R11: error and clear in the same cycle, flag already set
        txn(1'b0, 1'b1, 1'b1, 1'b1); txn_end();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = ALL1;
        txn_valid = 1'b1; txn_is_write = 1'b0; txn_hit = 1'b0;
        txn_src_fabric = 1'b0; txn_dst_fabric = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; txn_valid = 1'b0;
        #1;
        chk("R11 R3 rsp with clear", {31'b0, rsp_valid}, 1);
        rd(8'h00, d); chk("R11 set wins both flags", d, 32'h8000_0001);
        chk("R11 R10 irq stays", {31'b0, irq}, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule